// File: doc/BRIEF.md
# Closed-Loop Power Sequencer

This block brings a set of power groups (three by default) up and down in a fixed order. A sequence-up request enables the lowest group. Each later group is enabled only after a fresh voltage sample from the group before it reaches that group's high ramp threshold. A sequence-down request works from the top group downward. Each earlier group is disabled only after the group just switched off reports a sample below its low ramp threshold. Samples and thresholds are unsigned ADC codes. The thresholds are plain inputs, so they can be changed at any time and take effect on the next comparison.

When the block is not sequencing, each group can be switched on or off by itself. A programmable cycle limit guards every step. If a step does not see its crossing in time, the block stops in a fault state. In that state the enables stay frozen until a new sequence request arrives. Each group drives a status line that reports "powered and good".

Top module: `power_sequencer`

## Requirements
- R1: A sequence-up request taken while not sequencing sets enable bit 0 in the next cycle. Each later bit i is set only after bit i-1 is set. If up and down are requested in the same cycle, up wins.
- R2: A sequence-down request taken while not sequencing clears the top enable bit in the next cycle. Each lower bit is cleared only after the bit above it is clear.
- R3: During power-up, the step to group i+1 happens on the edge where group i presents a valid sample greater than or equal to its high threshold. A sample one code below the threshold causes no step.
- R4: During power-down, the step to group i-1 happens on the edge where group i presents a valid sample strictly below its low threshold. A sample equal to the threshold causes no step.
- R5: Changes to a threshold input apply from the next comparison, including in the middle of a step.
- R6: While idle, a per-group on request sets that enable and an off request clears it. If both arrive for the same group, off wins.
- R7: Per-group requests have no effect while a sequence is running.
- R8: Status bit i is 1 exactly when enable i is 1 and the last valid sample of group i is at or above its high threshold.
- R9: If a step waits more than the timeout limit in cycles, the block enters fault: fault=1 and busy=0. Enables and per-group requests are then frozen.
- R10: A sequence request that arrives while busy is ignored.
- R11: busy is 1 from the cycle after a sequence request is taken until the last step completes.
- R12: After reset, all enables, status bits, busy and fault are 0.
- R13: A sequence request clears fault and starts that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_up | input | 1 | Start power-up sequence (pulse) |
| seq_dn | input | 1 | Start power-down sequence (pulse) |
| grp_on | input | NUM_GRP | Per-group on request |
| grp_off | input | NUM_GRP | Per-group off request |
| vsamp | input | NUM_GRP*ADC_W | Packed per-group voltage samples, group i at bits [i*ADC_W +: ADC_W] |
| vsamp_vld | input | NUM_GRP | Per-group sample valid strobe |
| ramp_hi | input | NUM_GRP*ADC_W | Packed per-group high ramp thresholds |
| ramp_lo | input | NUM_GRP*ADC_W | Packed per-group low ramp thresholds |
| tmo_limit | input | TMO_W | Step timeout in cycles |
| grp_en | output | NUM_GRP | Per-group enables |
| grp_stat | output | NUM_GRP | Per-group power-good status |
| busy | output | 1 | A sequence is running |
| fault | output | 1 | A step timed out |

## Verification
The bound checker watches several rules on every cycle. While busy, the enables change by at most one bit per cycle. A rise or fall of an enable during a sequence respects the order of the groups. Every such step is paired with a valid sample of the neighbouring group that crosses its threshold. Once in fault, the enables stay still until a sequence request arrives. Only the bench scenarios can show the rest: the exact timeout window, that requests are ignored while busy, the equality boundaries of both comparisons, threshold changes in mid-step, the priority of off over on, and the status values.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_UP    = 2'd1,
      SQ_DOWN  = 2'd2,
      SQ_FAULT = 2'd3
   } sq_state_t;
endpackage

// File: rtl/pwrseq_grp_mon.sv
`timescale 1ns/1ps
module pwrseq_grp_mon #(
   parameter int ADC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [ADC_W-1:0] samp,
   input  logic [ADC_W-1:0] thr_hi,
   input  logic [ADC_W-1:0] thr_lo,
   output logic             hit_hi,
   output logic             hit_lo,
   output logic             good
);
   logic [ADC_W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= '0;
      else if (vld) last_q <= samp;
   end

   // Fresh-sample crossings drive sequencing; the held sample drives status
   assign hit_hi = vld && (samp >= thr_hi);
   assign hit_lo = vld && (samp <  thr_lo);
   assign good   = (last_q >= thr_hi);
endmodule

// File: rtl/pwrseq_ctrl.sv
`timescale 1ns/1ps
module pwrseq_ctrl
   import pwrseq_pkg::*;
#(
   parameter int NUM_GRP = 3,
   parameter int TMO_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seq_up,
   input  logic               seq_dn,
   input  logic [NUM_GRP-1:0] req_on,
   input  logic [NUM_GRP-1:0] req_off,
   input  logic [NUM_GRP-1:0] hit_hi,
   input  logic [NUM_GRP-1:0] hit_lo,
   input  logic [TMO_W-1:0]   tmo_limit,
   output logic [NUM_GRP-1:0] en,
   output logic               busy,
   output logic               fault
);
   localparam int IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_GRP - 1);

   sq_state_t        st;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] idx_up;
   logic [IDX_W-1:0] idx_dn;
   logic [TMO_W-1:0] tmr;

   assign idx_up = idx + 1'b1;
   assign idx_dn = idx - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         idx <= '0;
         en  <= '0;
         tmr <= '0;
      end else begin
         case (st)
            SQ_IDLE, SQ_FAULT: begin
               if (seq_up) begin
                  st    <= SQ_UP;
                  idx   <= '0;
                  en[0] <= 1'b1;
                  tmr   <= '0;
               end else if (seq_dn) begin
                  st       <= SQ_DOWN;
                  idx      <= LAST;
                  en[LAST] <= 1'b0;
                  tmr      <= '0;
               end else if (st == SQ_IDLE) begin
                  en <= (en | req_on) & ~req_off;
               end
            end
            SQ_UP: begin
               if (hit_hi[idx]) begin
                  tmr <= '0;
                  if (idx == LAST) st <= SQ_IDLE;
                  else begin
                     idx        <= idx_up;
                     en[idx_up] <= 1'b1;
                  end
               end else if (tmr >= tmo_limit) st <= SQ_FAULT;
               else tmr <= tmr + 1'b1;
            end
            SQ_DOWN: begin
               if (hit_lo[idx]) begin
                  tmr <= '0;
                  if (idx == '0) st <= SQ_IDLE;
                  else begin
                     idx        <= idx_dn;
                     en[idx_dn] <= 1'b0;
                  end
               end else if (tmr >= tmo_limit) st <= SQ_FAULT;
               else tmr <= tmr + 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy  = (st == SQ_UP) || (st == SQ_DOWN);
   assign fault = (st == SQ_FAULT);
endmodule

// File: rtl/power_sequencer.sv
`timescale 1ns/1ps
module power_sequencer #(
   parameter int NUM_GRP         = 3,
   parameter int ADC_W           = 12,
   parameter int TMO_W           = 16,
   parameter bit STAT_NEEDS_GOOD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     seq_up,
   input  logic                     seq_dn,
   input  logic [NUM_GRP-1:0]       grp_on,
   input  logic [NUM_GRP-1:0]       grp_off,
   input  logic [NUM_GRP*ADC_W-1:0] vsamp,
   input  logic [NUM_GRP-1:0]       vsamp_vld,
   input  logic [NUM_GRP*ADC_W-1:0] ramp_hi,
   input  logic [NUM_GRP*ADC_W-1:0] ramp_lo,
   input  logic [TMO_W-1:0]         tmo_limit,
   output logic [NUM_GRP-1:0]       grp_en,
   output logic [NUM_GRP-1:0]       grp_stat,
   output logic                     busy,
   output logic                     fault
);
   if (NUM_GRP < 2 || NUM_GRP > 16) begin : g_bad_num
      $error("power_sequencer: NUM_GRP must be within 2..16");
   end
   if (ADC_W < 2 || ADC_W > 24) begin : g_bad_adc
      $error("power_sequencer: ADC_W must be within 2..24");
   end
   if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo
      $error("power_sequencer: TMO_W must be within 2..32");
   end

   logic [NUM_GRP-1:0] hit_hi;
   logic [NUM_GRP-1:0] hit_lo;
   logic [NUM_GRP-1:0] good;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_mon
      pwrseq_grp_mon #(.ADC_W(ADC_W)) u_mon (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld    (vsamp_vld[g]),
         .samp   (vsamp[g*ADC_W +: ADC_W]),
         .thr_hi (ramp_hi[g*ADC_W +: ADC_W]),
         .thr_lo (ramp_lo[g*ADC_W +: ADC_W]),
         .hit_hi (hit_hi[g]),
         .hit_lo (hit_lo[g]),
         .good   (good[g])
      );
   end

   pwrseq_ctrl #(.NUM_GRP(NUM_GRP), .TMO_W(TMO_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq_up    (seq_up),
      .seq_dn    (seq_dn),
      .req_on    (grp_on),
      .req_off   (grp_off),
      .hit_hi    (hit_hi),
      .hit_lo    (hit_lo),
      .tmo_limit (tmo_limit),
      .en        (grp_en),
      .busy      (busy),
      .fault     (fault)
   );

   if (STAT_NEEDS_GOOD) begin : g_stat_good
      assign grp_stat = grp_en & good;
   end else begin : g_stat_en
      logic [NUM_GRP-1:0] unused_good;
      assign unused_good = good;
      assign grp_stat    = grp_en;
   end
endmodule

// File: rtl/pwrseq_chk.sv
`timescale 1ns/1ps
module pwrseq_chk #(
   parameter int NUM_GRP = 3,
   parameter int ADC_W   = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     seq_up,
   input logic                     seq_dn,
   input logic [NUM_GRP*ADC_W-1:0] vsamp,
   input logic [NUM_GRP-1:0]       vsamp_vld,
   input logic [NUM_GRP*ADC_W-1:0] ramp_hi,
   input logic [NUM_GRP*ADC_W-1:0] ramp_lo,
   input logic [NUM_GRP-1:0]       grp_en,
   input logic                     busy,
   input logic                     fault
);
   // R7: no per-group request can disturb a running sequence
   p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($countones(grp_en ^ $past(grp_en)) <= 1));

   // R9: enables frozen in fault until a sequence request
   p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !seq_up && !seq_dn) |=> (fault && $stable(grp_en)));

   for (genvar i = 1; i < NUM_GRP; i++) begin : g_up
      // R1: upward order
      p_up_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(busy) && $rose(grp_en[i])) |-> grp_en[i-1]);
      // R3: step up only on a crossing of the group below
      p_up_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(busy) && $rose(grp_en[i])) |->
            $past(vsamp_vld[i-1] &&
                  (vsamp[(i-1)*ADC_W +: ADC_W] >= ramp_hi[(i-1)*ADC_W +: ADC_W])));
   end

   for (genvar i = 0; i < NUM_GRP-1; i++) begin : g_dn
      // R2: downward order
      p_dn_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(busy) && $fell(grp_en[i])) |-> !grp_en[i+1]);
      // R4: step down only on a crossing of the group above
      p_dn_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(busy) && $fell(grp_en[i])) |->
            $past(vsamp_vld[i+1] &&
                  (vsamp[(i+1)*ADC_W +: ADC_W] < ramp_lo[(i+1)*ADC_W +: ADC_W])));
   end
endmodule

bind power_sequencer pwrseq_chk #(.NUM_GRP(NUM_GRP), .ADC_W(ADC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .seq_up    (seq_up),
   .seq_dn    (seq_dn),
   .vsamp     (vsamp),
   .vsamp_vld (vsamp_vld),
   .ramp_hi   (ramp_hi),
   .ramp_lo   (ramp_lo),
   .grp_en    (grp_en),
   .busy      (busy),
   .fault     (fault)
);

// File: tb/power_sequencer_test.sv
`timescale 1ns/1ps
module power_sequencer_test;
   localparam int N = 3;
   localparam int W = 12;
   localparam int T = 16;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           seq_up, seq_dn;
   logic [N-1:0]   grp_on, grp_off, vsamp_vld;
   logic [N*W-1:0] vsamp, ramp_hi, ramp_lo;
   logic [T-1:0]   tmo_limit;
   logic [N-1:0]   grp_en, grp_stat;
   logic           busy, fault;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   power_sequencer #(.NUM_GRP(N), .ADC_W(W), .TMO_W(T)) uut (
      .clk(clk), .rst_n(rst_n), .seq_up(seq_up), .seq_dn(seq_dn),
      .grp_on(grp_on), .grp_off(grp_off), .vsamp(vsamp), .vsamp_vld(vsamp_vld),
      .ramp_hi(ramp_hi), .ramp_lo(ramp_lo), .tmo_limit(tmo_limit),
      .grp_en(grp_en), .grp_stat(grp_stat), .busy(busy), .fault(fault)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // drive a single valid sample for one group for one cycle
   task automatic samp1(input int g, input logic [W-1:0] v);
      vsamp[g*W +: W] = v;
      vsamp_vld       = '0;
      vsamp_vld[g]    = 1'b1;
      step();
      vsamp_vld       = '0;
   endtask

   task automatic pulse_up();
      seq_up = 1'b1; step(); seq_up = 1'b0;
   endtask

   task automatic pulse_dn();
      seq_dn = 1'b1; step(); seq_dn = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12 en", 32'(grp_en), 0);
      chk("R12 stat", 32'(grp_stat), 0);
      chk("R12 busy", 32'(busy), 0);
      chk("R12 fault", 32'(fault), 0);
   endtask

   task automatic t_seq_up();
      pulse_up();
      chk("R1 first group", 32'(grp_en), 32'b001);
      chk("R11 busy set", 32'(busy), 1);
      vsamp[0 +: W] = 12'h7FF; vsamp_vld = 3'b001;
      step(3); vsamp_vld = '0;
      chk("R3 below hi no step", 32'(grp_en), 32'b001);
      chk("R8 stat not good", 32'(grp_stat), 0);
      samp1(0, 12'h800);
      chk("R3 equal hi steps", 32'(grp_en), 32'b011);
      chk("R8 stat group0", 32'(grp_stat), 32'b001);
      samp1(1, 12'h900);
      chk("R1 second step", 32'(grp_en), 32'b111);
      chk("R11 still busy", 32'(busy), 1);
      samp1(2, 12'hFFF);
      chk("R11 busy done", 32'(busy), 0);
      chk("R8 all good", 32'(grp_stat), 32'b111);
   endtask

   task automatic t_seq_down();
      pulse_dn();
      chk("R2 top first", 32'(grp_en), 32'b011);
      chk("R8 stat follows en", 32'(grp_stat), 32'b011);
      vsamp[2*W +: W] = 12'h100; vsamp_vld = 3'b100;
      step(2); vsamp_vld = '0;
      chk("R4 equal lo no step", 32'(grp_en), 32'b011);
      samp1(2, 12'h0FF);
      chk("R4 below lo steps", 32'(grp_en), 32'b001);
      samp1(1, 12'h000);
      chk("R2 last disabled", 32'(grp_en), 32'b000);
      chk("R11 busy until last", 32'(busy), 1);
      samp1(0, 12'h050);
      chk("R11 busy clear", 32'(busy), 0);
   endtask

   task automatic finish_up_from0();
      samp1(0, 12'h900); samp1(1, 12'h900); samp1(2, 12'h900);
   endtask

   task automatic t_busy_ignore();
      pulse_up();
      seq_dn = 1'b1; grp_on = 3'b100; grp_off = 3'b001;
      step();
      seq_dn = 1'b0; grp_on = '0; grp_off = '0;
      chk("R7 R10 ignored while busy", 32'(grp_en), 32'b001);
      chk("R10 still up busy", 32'(busy), 1);
      finish_up_from0();
      chk("R1 completed", 32'(grp_en), 32'b111);
      chk("R11 idle", 32'(busy), 0);
   endtask

   task automatic t_indiv();
      grp_off = 3'b010; step(); grp_off = '0;
      chk("R6 off one", 32'(grp_en), 32'b101);
      grp_on = 3'b010; grp_off = 3'b010; step(); grp_on = '0; grp_off = '0;
      chk("R6 off wins", 32'(grp_en), 32'b101);
      grp_off = 3'b101; step(); grp_off = '0;
      chk("R6 off two", 32'(grp_en), 32'b000);
      grp_on = 3'b100; step(); grp_on = '0;
      chk("R6 on one", 32'(grp_en), 32'b100);
      chk("R8 stat held sample", 32'(grp_stat), 32'b100);
      seq_up = 1'b1; seq_dn = 1'b1; step(); seq_up = 1'b0; seq_dn = 1'b0;
      chk("R1 up wins", 32'(grp_en), 32'b101);
      finish_up_from0();
      chk("R1 all on", 32'(grp_en), 32'b111);
   endtask

   task automatic t_runtime();
      pulse_dn();
      chk("R2 start down", 32'(grp_en), 32'b011);
      ramp_lo[2*W +: W] = 12'h050;
      samp1(2, 12'h080);
      chk("R5 lowered lo no step", 32'(grp_en), 32'b011);
      ramp_lo[2*W +: W] = 12'h100;
      samp1(2, 12'h080);
      chk("R5 raised lo steps", 32'(grp_en), 32'b001);
      samp1(1, 12'h000); samp1(0, 12'h000);
      chk("R2 all off", 32'(grp_en), 32'b000);
   endtask

   task automatic t_timeout();
      pulse_up();
      step(10);
      chk("R9 no early fault", 32'(fault), 0);
      step(20);
      chk("R9 fault", 32'(fault), 1);
      chk("R9 busy clear", 32'(busy), 0);
      chk("R9 en kept", 32'(grp_en), 32'b001);
      grp_on = 3'b110; step(); grp_on = '0;
      chk("R9 indiv frozen", 32'(grp_en), 32'b001);
      samp1(0, 12'hFFF);
      chk("R9 samples frozen", 32'(grp_en), 32'b001);
      pulse_dn();
      chk("R13 fault cleared", 32'(fault), 0);
      chk("R13 busy", 32'(busy), 1);
      samp1(2, 12'h000); samp1(1, 12'h000);
      chk("R13 down proceeds", 32'(grp_en), 32'b000);
      samp1(0, 12'h000);
      chk("R13 idle", 32'(busy), 0);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; seq_up = 1'b0; seq_dn = 1'b0;
      grp_on = '0; grp_off = '0; vsamp = '0; vsamp_vld = '0;
      for (int g = 0; g < N; g++) begin
         ramp_hi[g*W +: W] = 12'h800;
         ramp_lo[g*W +: W] = 12'h100;
      end
      tmo_limit = 16'd20;
      step(3);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_seq_up();
      t_seq_down();
      t_busy_ignore();
      t_indiv();
      t_runtime();
      t_timeout();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule